// File: doc/BRIEF.md
# Store Override Control Patch

This block sits between an existing instruction decoder and the datapath it steers. The original decoder has store opcodes whose bus-source field picks RAM. RAM cannot drive the bus during its own write cycle, so those opcodes used to store undefined data. The block gives that group of opcodes a new meaning: store the accumulator, with the high address byte taken from X instead of Y. A store through [Y,D] becomes a store through [X,D], and a store through [Y,X] becomes a store through [X,X]. Every other opcode reaches the datapath exactly as the original decoder produced it, so existing programs run unchanged.

The block is purely combinational. All control lines are active-low. The high-address select line is also active-low: 0 picks X and 1 picks Y. The parameter `POST_INC` chooses the variant. At 0 the new mode is [X,D]. At 1 the override also pulses the X-increment line, which gives [X++,D] for block copies.

Top module: `store_ovr_dec`

## Requirements
- R1: The override is active when the write strobe `we_ni` is low (0) and the 2-bit bus-source code `bus_mode_i` equals the RAM code 2'b01. No other input combination activates it.
- R2: While the override is active, `ram_oe_no` is high, so RAM does not drive the bus.
- R3: While the override is active, `ac_en_no` is low, so the accumulator drives the bus and is the value written.
- R4: While the override is active, `hi_x_sel_no` is low, so the high address comes from X instead of Y.
- R5: With `POST_INC`=1 the override drives `x_inc_no` low. With `POST_INC`=0 the override leaves `x_inc_no` equal to `x_inc_ni`.
- R6: For non-store opcodes, including RAM reads with bus code 2'b01, every output equals its matching input.
- R7: For store opcodes whose bus code is not 2'b01, every output equals its matching input.
- R8: `we_no` always equals `we_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_mode_i | input | 2 | Bus-source field of the current opcode (2'b01 = RAM) |
| ram_oe_ni | input | 1 | Original RAM output enable, active-low |
| ac_en_ni | input | 1 | Original accumulator bus enable, active-low |
| we_ni | input | 1 | Original write strobe, active-low |
| hi_x_sel_ni | input | 1 | Original high-address select, 0 = X, 1 = Y |
| x_inc_ni | input | 1 | Original X-increment, active-low |
| ram_oe_no | output | 1 | Corrected RAM output enable |
| ac_en_no | output | 1 | Corrected accumulator bus enable |
| we_no | output | 1 | Write strobe, passed through |
| hi_x_sel_no | output | 1 | Corrected high-address select |
| x_inc_no | output | 1 | Corrected X-increment |

## Verification
The hard case is separating the eight overridden store opcodes from the RAM-sourced loads. Both groups present bus code 2'b01 and differ only in the write strobe. The other case is the store through [Y,X++], where the original decoder already pulses the increment. The stimulus therefore sweeps all 256 opcodes through a model of the original decoder and feeds its control lines to both parameter variants. A scoreboard compares each output field against the patched model. Finally the bench confirms that each variant differs from the original decoder on exactly the eight opcodes of the overridden group.

// File: rtl/sod_pkg.sv
package sod_pkg;
  typedef struct packed {
    logic ram_oe_n;
    logic ac_en_n;
    logic we_n;
    logic hi_x_sel_n;
    logic x_inc_n;
  } ctl_t;
endpackage

// File: rtl/sod_detect.sv
module sod_detect #(
  parameter int unsigned         BUS_W    = 2,
  parameter logic [BUS_W-1:0]    RAM_CODE = 2'b01
) (
  input  logic [BUS_W-1:0] bus_mode_i,
  input  logic             we_ni,
  output logic             ovr_o
);
  always_comb ovr_o = !we_ni && (bus_mode_i == RAM_CODE);
endmodule

// File: rtl/sod_bus_patch.sv
module sod_bus_patch (
  input  logic ovr_i,
  input  logic ram_oe_ni,
  input  logic ac_en_ni,
  output logic ram_oe_no,
  output logic ac_en_no
);
  // accumulator replaces RAM as bus source during the overridden store
  always_comb begin
    ram_oe_no = ovr_i ? 1'b1 : ram_oe_ni;
    ac_en_no  = ovr_i ? 1'b0 : ac_en_ni;
  end
endmodule

// File: rtl/sod_addr_patch.sv
module sod_addr_patch #(
  parameter bit POST_INC = 1'b0
) (
  input  logic ovr_i,
  input  logic hi_x_sel_ni,
  input  logic x_inc_ni,
  output logic hi_x_sel_no,
  output logic x_inc_no
);
  always_comb hi_x_sel_no = ovr_i ? 1'b0 : hi_x_sel_ni;

  generate
    if (POST_INC) begin : g_post_inc
      always_comb x_inc_no = ovr_i ? 1'b0 : x_inc_ni;
    end else begin : g_plain
      always_comb x_inc_no = x_inc_ni;
    end
  endgenerate
endmodule

// File: rtl/store_ovr_dec.sv
module store_ovr_dec
  import sod_pkg::*;
#(
  parameter bit          POST_INC = 1'b0,
  parameter int unsigned BUS_W    = 2
) (
  input  logic [BUS_W-1:0] bus_mode_i,
  input  logic             ram_oe_ni,
  input  logic             ac_en_ni,
  input  logic             we_ni,
  input  logic             hi_x_sel_ni,
  input  logic             x_inc_ni,
  output logic             ram_oe_no,
  output logic             ac_en_no,
  output logic             we_no,
  output logic             hi_x_sel_no,
  output logic             x_inc_no
);
  localparam logic [BUS_W-1:0] RAM_CODE = BUS_W'(1);

  ctl_t ctl_in, ctl_out;
  logic ovr;

  always_comb begin
    ctl_in.ram_oe_n   = ram_oe_ni;
    ctl_in.ac_en_n    = ac_en_ni;
    ctl_in.we_n       = we_ni;
    ctl_in.hi_x_sel_n = hi_x_sel_ni;
    ctl_in.x_inc_n    = x_inc_ni;
  end

  sod_detect #(.BUS_W(BUS_W), .RAM_CODE(RAM_CODE)) u_detect (
    .bus_mode_i (bus_mode_i),
    .we_ni      (ctl_in.we_n),
    .ovr_o      (ovr)
  );

  sod_bus_patch u_bus (
    .ovr_i     (ovr),
    .ram_oe_ni (ctl_in.ram_oe_n),
    .ac_en_ni  (ctl_in.ac_en_n),
    .ram_oe_no (ctl_out.ram_oe_n),
    .ac_en_no  (ctl_out.ac_en_n)
  );

  sod_addr_patch #(.POST_INC(POST_INC)) u_addr (
    .ovr_i       (ovr),
    .hi_x_sel_ni (ctl_in.hi_x_sel_n),
    .x_inc_ni    (ctl_in.x_inc_n),
    .hi_x_sel_no (ctl_out.hi_x_sel_n),
    .x_inc_no    (ctl_out.x_inc_n)
  );

  always_comb ctl_out.we_n = ctl_in.we_n;

  always_comb begin
    ram_oe_no   = ctl_out.ram_oe_n;
    ac_en_no    = ctl_out.ac_en_n;
    we_no       = ctl_out.we_n;
    hi_x_sel_no = ctl_out.hi_x_sel_n;
    x_inc_no    = ctl_out.x_inc_n;
  end
endmodule

// File: rtl/sod_checker.sv
module sod_checker #(
  parameter bit          POST_INC = 1'b0,
  parameter int unsigned BUS_W    = 2
) (
  input logic [BUS_W-1:0] bus_mode_i,
  input logic             ram_oe_ni,
  input logic             ac_en_ni,
  input logic             we_ni,
  input logic             hi_x_sel_ni,
  input logic             x_inc_ni,
  input logic             ram_oe_no,
  input logic             ac_en_no,
  input logic             we_no,
  input logic             hi_x_sel_no,
  input logic             x_inc_no
);
  logic known, store_ram;

  always_comb begin
    known     = !$isunknown({bus_mode_i, ram_oe_ni, ac_en_ni, we_ni, hi_x_sel_ni, x_inc_ni,
                             ram_oe_no, ac_en_no, we_no, hi_x_sel_no, x_inc_no});
    store_ram = (we_ni == 1'b0) && (bus_mode_i == BUS_W'(1));
    if (known) begin
      p_oe_off_r2: assert (!store_ram || ram_oe_no);
      p_ac_on_r3: assert (!store_ram || !ac_en_no);
      p_hi_x_r4: assert (!store_ram || !hi_x_sel_no);
      if (POST_INC) begin
        p_inc_r5: assert (!store_ram || !x_inc_no);
      end else begin
        p_inc_keep_r5: assert (x_inc_no == x_inc_ni);
      end
      p_pass_r6: assert (!we_ni ||
                         {ram_oe_no, ac_en_no, hi_x_sel_no, x_inc_no} ==
                         {ram_oe_ni, ac_en_ni, hi_x_sel_ni, x_inc_ni});
      p_pass_store_r7: assert (we_ni || store_ram ||
                         {ram_oe_no, ac_en_no, hi_x_sel_no, x_inc_no} ==
                         {ram_oe_ni, ac_en_ni, hi_x_sel_ni, x_inc_ni});
      p_we_r8: assert (we_no == we_ni);
    end
  end
endmodule

bind store_ovr_dec sod_checker #(.POST_INC(POST_INC), .BUS_W(BUS_W)) u_chk (
  .bus_mode_i  (bus_mode_i),
  .ram_oe_ni   (ram_oe_ni),
  .ac_en_ni    (ac_en_ni),
  .we_ni       (we_ni),
  .hi_x_sel_ni (hi_x_sel_ni),
  .x_inc_ni    (x_inc_ni),
  .ram_oe_no   (ram_oe_no),
  .ac_en_no    (ac_en_no),
  .we_no       (we_no),
  .hi_x_sel_no (hi_x_sel_no),
  .x_inc_no    (x_inc_no)
);

// File: tb/store_ovr_dec_tb.sv
module store_ovr_dec_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct packed {
    logic oe, ac, we, hs, xi;
  } sig_t;

  typedef struct packed {
    logic [7:0] op;
    logic       ovr;
    sig_t       orig;
    sig_t       exp0;
    sig_t       exp1;
  } item_t;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0] bus_mode;
  sig_t       drv;
  sig_t       out0, out1;

  int checks = 0;
  int fails  = 0;
  int diff0  = 0;
  int diff1  = 0;
  bit done   = 1'b0;
  item_t q[$];

  store_ovr_dec #(.POST_INC(1'b0)) u_dut (
    .bus_mode_i (bus_mode), .ram_oe_ni (drv.oe), .ac_en_ni (drv.ac), .we_ni (drv.we),
    .hi_x_sel_ni (drv.hs), .x_inc_ni (drv.xi),
    .ram_oe_no (out0.oe), .ac_en_no (out0.ac), .we_no (out0.we),
    .hi_x_sel_no (out0.hs), .x_inc_no (out0.xi)
  );

  store_ovr_dec #(.POST_INC(1'b1)) u_dut_inc (
    .bus_mode_i (bus_mode), .ram_oe_ni (drv.oe), .ac_en_ni (drv.ac), .we_ni (drv.we),
    .hi_x_sel_ni (drv.hs), .x_inc_ni (drv.xi),
    .ram_oe_no (out1.oe), .ac_en_no (out1.ac), .we_no (out1.we),
    .hi_x_sel_no (out1.hs), .x_inc_no (out1.xi)
  );

  // model of the original decoder: op[7:5] group (110 store, 111 jump), op[4:2] mode, op[1:0] bus
  function automatic sig_t orig_dec(input logic [7:0] op);
    sig_t s;
    logic store, jump;
    store = (op[7:5] == 3'b110);
    jump  = (op[7:5] == 3'b111);
    s.oe  = !(op[1:0] == 2'b01);
    s.ac  = !(op[1:0] == 2'b10);
    s.we  = !store;
    s.hs  = 1'b1;
    s.xi  = !(op[4:2] == 3'b111 && !jump);
    return s;
  endfunction

  function automatic sig_t patched(input sig_t o, input logic [1:0] bus, input bit pi);
    sig_t s = o;
    if (!o.we && bus == 2'b01) begin
      s.oe = 1'b1;
      s.ac = 1'b0;
      s.hs = 1'b0;
      if (pi) s.xi = 1'b0;
    end
    return s;
  endfunction

  task automatic check_bit(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic check_item(input item_t it, input sig_t act, input sig_t exp, input string tag);
    string base;
    base = it.ovr ? "" : (it.orig.we ? "R6" : "R7");
    check_bit(it.ovr ? "R2" : base, $sformatf("%s op=%02h oe", tag, it.op), act.oe, exp.oe);
    check_bit(it.ovr ? "R3" : base, $sformatf("%s op=%02h ac", tag, it.op), act.ac, exp.ac);
    check_bit("R8", $sformatf("%s op=%02h we", tag, it.op), act.we, exp.we);
    check_bit(it.ovr ? "R4" : base, $sformatf("%s op=%02h hs", tag, it.op), act.hs, exp.hs);
    check_bit(it.ovr ? "R5" : base, $sformatf("%s op=%02h xi", tag, it.op), act.xi, exp.xi);
  endtask

  // monitor: results settle by the next rising edge after the negedge drive
  always @(posedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check_item(it, out0, it.exp0, "xd");
      check_item(it, out1, it.exp1, "xinc");
      if (out0 != it.orig) diff0++;
      if (out1 != it.orig) diff1++;
    end
  end

  initial begin
    bus_mode = 2'b00;
    drv      = '1;
    #(CLK_PERIOD/4);
    // idle state: nothing asserted in, nothing asserted out (R6)
    checks++;
    if (out0 !== 5'b11111 || out1 !== 5'b11111) begin
      fails++;
      $display("FAIL R6 idle: actual %b/%b expected 11111", out0, out1);
    end
    for (int i = 0; i < 256; i++) begin
      item_t it;
      logic [7:0] op;
      op = 8'(i);
      @(negedge clk);
      it.op   = op;
      it.orig = orig_dec(op);
      it.ovr  = !it.orig.we && op[1:0] == 2'b01;
      it.exp0 = patched(it.orig, op[1:0], 1'b0);
      it.exp1 = patched(it.orig, op[1:0], 1'b1);
      bus_mode = op[1:0];
      drv      = it.orig;
      q.push_back(it);
    end
    repeat (3) @(posedge clk);
    #1;
    // only the eight store-from-RAM opcodes may differ from the original decoder (R1)
    checks++;
    if (diff0 != 8) begin
      fails++;
      $display("FAIL R1 differing opcodes [X,D]: actual %0d expected 8", diff0);
    end
    checks++;
    if (diff1 != 8) begin
      fails++;
      $display("FAIL R1 differing opcodes [X++,D]: actual %0d expected 8", diff1);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule